// File: doc/BRIEF.md
# Dual-Clock Byte-to-Nibble Output FIFO

This block is a shallow dual-clock FIFO that sits between a fabric clock domain and an I/O transmit clock domain. The write side takes one word per write-clock cycle that holds ten 8-bit lanes. On the read clock the block presents 4-bit lanes that are ready to pass to a downstream serialiser or output register. The read data is first-word-fall-through: whenever `empty` is low, `rd_data` already shows the item that the next read will consume.

A parameter selects one of two lane arrangements. In split mode, which is the default and is meant for a read clock at about twice the write clock, each stored byte is sent out over two reads through a 2:1 multiplexer in every lane. In pass mode each read sends out twelve 4-bit lanes: ten lanes use the low nibbles, and two more lanes travel in the upper nibbles of lanes 5 and 6. Storage is an 8-entry dual-clock store followed by one output register on the read side. Pointers cross between the domains in Gray code through two-stage synchronisers. An active-high asynchronous reset is brought into each domain through its own synchroniser. A build option can force every output bit high while read enable is low.

Top module: `byte_nibble_ofifo`

## Requirements
- R1: After reset is released, `empty` and `almost_empty` are high and `full` and `almost_full` are low.
- R2: Words leave the FIFO in the order they were written, and no word is lost or duplicated during concurrent traffic on both clocks.
- R3: The FIFO holds at most DEPTH+1 words: DEPTH in the store plus one in the output register. `full` is high exactly when the store holds DEPTH words, and the output register is not counted.
- R4: A write attempted while `full` is high has no effect.
- R5: A read attempted while `empty` is high has no effect. The next word written is still the next one read.
- R6: In split mode (SPLIT=1), each word takes two reads. The first read shows bits [3:0] of each lane byte on `rd_data[8k+3:8k]`, and the second read shows bits [7:4]. Bits [8k+7:8k+4] are 0.
- R7: In pass mode (SPLIT=0), one read shows `rd_data[8k+3:8k]` = `wr_data[8k+3:8k]` for lanes 0 to 9. Bits [47:44] and [55:52] carry the upper nibbles of lanes 5 and 6. All other upper output nibbles are 0, and all other upper input nibbles are ignored.
- R8: `empty` is low exactly while the output register holds a word. In split mode it stays low between the two nibble reads of one word.
- R9: `almost_empty` is high when the number of words visible to the read side (the output register plus the store) is at most AE_LEVEL, where AE_LEVEL is 1 or 2.
- R10: `almost_full` is high when the store count seen by the write side is at least DEPTH-AF_LEVEL, where AF_LEVEL is 1 or 2.
- R11: With OUT_DISABLE=1, every bit of `rd_data` is 1 while `rd_en` is low. With OUT_DISABLE=0, `rd_en` does not mask the data.
- R12: A reset asserted during traffic discards all stored words. After release, the FIFO is empty and carries new words correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high asynchronous reset, synchronised into both domains |
| wr_clk | input | 1 | Write (fabric) clock |
| wr_en | input | 1 | Write request |
| wr_data | input | LANES*2*NIB_W | Ten 8-bit lanes |
| full | output | 1 | Store full, write-clock domain |
| almost_full | output | 1 | Store within AF_LEVEL of full, write-clock domain |
| rd_clk | input | 1 | Read (I/O) clock |
| rd_en | input | 1 | Read request |
| rd_data | output | LANES*2*NIB_W | Nibble lanes, mapped as in R6 and R7 |
| empty | output | 1 | No word in the output register, read-clock domain |
| almost_empty | output | 1 | Read-side word count at or below AE_LEVEL |

## Verification
The assertions assume the following:
- Both clocks run throughout.
- Reset is held for several cycles of the slower clock.
- Neither enable is raised while the local synchronised resets are still active.

The stimulus holds reset for six write-clock cycles with both enables low and waits before starting traffic. Because the crossing delay makes flag timing depend on clock phase, the flag levels are compared only after the traffic has settled. The data path is compared on every read-clock cycle.

// File: rtl/bnof_pkg.sv
package bnof_pkg;
  // Lane arrangement on the read side.
  typedef enum logic {
    LANE_PASS  = 1'b0,
    LANE_SPLIT = 1'b1
  } lane_mode_e;

  // Upper-nibble carriers used in pass mode.
  localparam int XLANE_A = 5;
  localparam int XLANE_B = 6;
endpackage

// File: rtl/bnof_rst_sync.sv
module bnof_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic srst
);
  logic [STAGES-1:0] chain;

  // Asserts at once, releases on this clock after STAGES edges.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign srst = chain[STAGES-1];
endmodule

// File: rtl/bnof_ptr_sync.sv
module bnof_ptr_sync #(
  parameter int PW     = 4,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  // Gray to binary on the synchronised value.
  always_comb begin
    bin_out[PW-1] = st[STAGES-1][PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ st[STAGES-1][i];
  end
endmodule

// File: rtl/bnof_store.sv
module bnof_store #(
  parameter int W     = 80,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read suits distributed RAM at this depth.
  assign rdata = mem[raddr];
endmodule

// File: rtl/bnof_wr_side.sv
module bnof_wr_side #(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   rbin_s,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wfire,
  output logic          full,
  output logic          almost_full
);
  logic [AW:0] wbin, wbin_inc, wcnt;

  assign wbin_inc    = wbin + 1'b1;
  assign wcnt        = wbin - rbin_s;
  assign full        = (wcnt == (AW+1)'(DEPTH));
  assign almost_full = (wcnt >= (AW+1)'(DEPTH - AF_LEVEL));
  assign wfire       = wr_en & ~full;
  assign waddr       = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wfire) begin
      wbin  <= wbin_inc;
      wgray <= wbin_inc ^ (wbin_inc >> 1);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wcnt <= (AW+1)'(DEPTH));

  // R10
  af_covers_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);

  // R2
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/bnof_rd_side.sv
module bnof_rd_side #(
  parameter int W        = 80,
  parameter int DEPTH    = 8,
  parameter int AE_LEVEL = 1,
  parameter bit SPLIT    = 1'b1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wbin_s,
  input  logic [W-1:0]  rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  word,
  output logic          phase,
  output logic          empty,
  output logic          almost_empty
);
  logic [AW:0]   rbin, rbin_inc, scnt;
  logic [AW+1:0] avail;
  logic          held, take, half, load;

  assign rbin_inc     = rbin + 1'b1;
  assign scnt         = wbin_s - rbin;
  assign avail        = {1'b0, scnt} + {{(AW+1){1'b0}}, held};
  assign empty        = ~held;
  assign almost_empty = (avail <= (AW+2)'(AE_LEVEL));
  assign raddr        = rbin[AW-1:0];

  assign take = rd_en & held & (SPLIT ? phase : 1'b1);
  assign half = SPLIT & rd_en & held & ~phase;
  assign load = (scnt != '0) & (~held | take);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      held  <= 1'b0;
      phase <= 1'b0;
      word  <= '0;
    end else if (load) begin
      word  <= rdata;
      held  <= 1'b1;
      phase <= 1'b0;
      rbin  <= rbin_inc;
      rgray <= rbin_inc ^ (rbin_inc >> 1);
    end else if (take) begin
      held  <= 1'b0;
      phase <= 1'b0;
    end else if (half) begin
      phase <= 1'b1;
    end
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    scnt <= (AW+1)'(DEPTH));

  // R9
  ae_covers_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);

  generate
    if (SPLIT) begin : g_pair
      // R8
      nibble_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && !phase) |=> (!empty && phase));
    end
  endgenerate
endmodule

// File: rtl/byte_nibble_ofifo.sv
module byte_nibble_ofifo
  import bnof_pkg::*;
#(
  parameter int LANES       = 10,
  parameter int NIB_W       = 4,
  parameter int DEPTH       = 8,
  parameter bit SPLIT       = 1'b1,
  parameter int AE_LEVEL    = 1,
  parameter int AF_LEVEL    = 1,
  parameter bit OUT_DISABLE = 1'b0,
  localparam int LW         = 2 * NIB_W,
  localparam int W          = LANES * LW,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic         rst,
  input  logic         wr_clk,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         almost_full,
  input  logic         rd_clk,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         almost_empty
);
  localparam lane_mode_e MODE = SPLIT ? LANE_SPLIT : LANE_PASS;

  logic          wrst, rrst, wfire, phase;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wbin_s, rbin_s;
  logic [W-1:0]  rdata, word, mapped;

  bnof_rst_sync u_wrst (.clk(wr_clk), .arst(rst), .srst(wrst));
  bnof_rst_sync u_rrst (.clk(rd_clk), .arst(rst), .srst(rrst));

  bnof_ptr_sync #(.PW(AW+1)) u_w2r (
    .clk(rd_clk), .rst(rrst), .gray_in(wgray), .bin_out(wbin_s));
  bnof_ptr_sync #(.PW(AW+1)) u_r2w (
    .clk(wr_clk), .rst(wrst), .gray_in(rgray), .bin_out(rbin_s));

  bnof_wr_side #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_wr (
    .clk(wr_clk), .rst(wrst), .wr_en(wr_en), .rbin_s(rbin_s),
    .waddr(waddr), .wgray(wgray), .wfire(wfire),
    .full(full), .almost_full(almost_full));

  bnof_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .wclk(wr_clk), .we(wfire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata));

  bnof_rd_side #(.W(W), .DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .SPLIT(SPLIT)) u_rd (
    .clk(rd_clk), .rst(rrst), .rd_en(rd_en), .wbin_s(wbin_s), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .word(word), .phase(phase),
    .empty(empty), .almost_empty(almost_empty));

  // Per-lane output mapping.
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (MODE == LANE_SPLIT) begin : g_split
        assign mapped[k*LW +: NIB_W]       = phase ? word[k*LW+NIB_W +: NIB_W]
                                                   : word[k*LW +: NIB_W];
        assign mapped[k*LW+NIB_W +: NIB_W] = '0;
      end else begin : g_pass
        assign mapped[k*LW +: NIB_W] = word[k*LW +: NIB_W];
        if (k == XLANE_A || k == XLANE_B) begin : g_extra
          assign mapped[k*LW+NIB_W +: NIB_W] = word[k*LW+NIB_W +: NIB_W];
        end else begin : g_zero
          assign mapped[k*LW+NIB_W +: NIB_W] = '0;
        end
      end
    end

    if (OUT_DISABLE) begin : g_dis
      assign rd_data = rd_en ? mapped : '1;
    end else begin : g_nodis
      assign rd_data = mapped;
    end
  endgenerate
endmodule

// File: tb/byte_nibble_ofifo_tb.sv
module byte_nibble_ofifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 80;

  logic rst = 1'b0, rclk = 1'b0, wclk = 1'b0;
  always #(CLK_PERIOD/2) rclk = ~rclk;
  always #(CLK_PERIOD)   wclk = ~wclk;

  logic         we_a = 0, we_b = 0, re_a = 0, re_b = 0;
  logic [W-1:0] wd_a = '0, wd_b = '0, q_a, q_b;
  logic full_a, af_a, empty_a, ae_a, full_b, af_b, empty_b, ae_b;
  logic wr_want_a = 0, wr_want_b = 0, rd_want_a = 0, rd_want_b = 0;

  logic [W-1:0] qa [$];
  logic [W-1:0] qb [$];
  bit pha = 0;
  int n_cmp = 0, n_bad = 0;

  // Default build: split mode, thresholds 1, no output disable.
  byte_nibble_ofifo u_dut (
    .rst(rst), .wr_clk(wclk), .wr_en(we_a), .wr_data(wd_a), .full(full_a),
    .almost_full(af_a), .rd_clk(rclk), .rd_en(re_a), .rd_data(q_a),
    .empty(empty_a), .almost_empty(ae_a));

  // Pass mode, thresholds 2, output disable on.
  byte_nibble_ofifo #(.SPLIT(1'b0), .AE_LEVEL(2), .AF_LEVEL(2), .OUT_DISABLE(1'b1)) u_dut_b (
    .rst(rst), .wr_clk(wclk), .wr_en(we_b), .wr_data(wd_b), .full(full_b),
    .almost_full(af_b), .rd_clk(rclk), .rd_en(re_b), .rd_data(q_b),
    .empty(empty_b), .almost_empty(ae_b));

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk1(logic act, logic exp, string req);
    chk(act === exp, req, W'(act), W'(exp));
  endtask

  function automatic logic [W-1:0] expect_q(logic [W-1:0] w, bit split, bit ph);
    logic [W-1:0] r = '0;
    for (int k = 0; k < 10; k++) begin
      if (split) r[k*8 +: 4] = ph ? w[k*8+4 +: 4] : w[k*8 +: 4];
      else begin
        r[k*8 +: 4] = w[k*8 +: 4];
        if (k == 5 || k == 6) r[k*8+4 +: 4] = w[k*8+4 +: 4];
      end
    end
    return r;
  endfunction

  // Write-side model: a word is kept only if full was low (R4).
  always @(negedge wclk) begin
    we_a = wr_want_a; we_b = wr_want_b;
    wd_a = W'({$urandom, $urandom, $urandom});
    wd_b = W'({$urandom, $urandom, $urandom});
    if (we_a && !full_a) qa.push_back(wd_a);
    if (we_b && !full_b) qb.push_back(wd_b);
  end

  // Read-side comparison on every read-clock cycle.
  always @(negedge rclk) begin
    re_a = rd_want_a; re_b = rd_want_b;
    #1;
    if (re_a && !empty_a) begin
      if (qa.size() == 0) chk(0, "R2 unexpected word", q_a, '0);
      else begin
        // R6 low nibble first, then high
        chk(q_a === expect_q(qa[0], 1, pha), "R6 split data", q_a, expect_q(qa[0], 1, pha));
        if (pha) begin void'(qa.pop_front()); pha = 0; end
        else pha = 1;
      end
    end
    if (!re_b) begin
      // R11 outputs forced high
      chk(q_b === '1, "R11 output disable", q_b, '1);
    end else if (!empty_b) begin
      if (qb.size() == 0) chk(0, "R2 unexpected word", q_b, '0);
      else begin
        // R7 pass-mode mapping
        chk(q_b === expect_q(qb[0], 0, 0), "R7 pass data", q_b, expect_q(qb[0], 0, 0));
        void'(qb.pop_front());
      end
    end
  end

  task automatic wcyc(int n);
    repeat (n) @(posedge wclk);
    #1;
  endtask

  task automatic put_one();
    @(posedge wclk); #1; wr_want_a = 1; wr_want_b = 1;
    @(posedge wclk); #1; wr_want_a = 0; wr_want_b = 0;
  endtask

  task automatic do_reset();
    wr_want_a = 0; wr_want_b = 0; rd_want_a = 0; rd_want_b = 0;
    wcyc(1);
    rst = 1;
    wcyc(6);
    qa.delete(); qb.delete(); pha = 0;
    rst = 0;
    wcyc(5);
  endtask

  // Settled flag levels from the word count n (store = n-1 when n>0).
  task automatic chk_levels(string tag);
    int na = qa.size(), nb = qb.size();
    int sa = (na > 0) ? na - 1 : 0, sb = (nb > 0) ? nb - 1 : 0;
    chk1(empty_a, na == 0, {"R8 empty a ", tag});
    chk1(empty_b, nb == 0, {"R8 empty b ", tag});
    chk1(ae_a, na <= 1, {"R9 almost_empty a ", tag});
    chk1(ae_b, nb <= 2, {"R9 almost_empty b ", tag});
    chk1(af_a, sa >= 7, {"R10 almost_full a ", tag});
    chk1(af_b, sb >= 6, {"R10 almost_full b ", tag});
    chk1(full_a, sa == 8, {"R3 full a ", tag});
    chk1(full_b, sb == 8, {"R3 full b ", tag});
  endtask

  task automatic drain();
    rd_want_a = 1; rd_want_b = 1;
    for (int i = 0; i < 200 && (qa.size() > 0 || qb.size() > 0); i++) @(posedge rclk);
    wcyc(4);
    rd_want_a = 0; rd_want_b = 0;
    wcyc(4);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    #1 rst = 1;
    wcyc(6);
    rst = 0;
    wcyc(5);
    // R1 reset state
    chk1(empty_a, 1, "R1 empty"); chk1(ae_a, 1, "R1 almost_empty");
    chk1(full_a, 0, "R1 full");   chk1(af_a, 0, "R1 almost_full");
    chk1(empty_b, 1, "R1 empty b"); chk1(full_b, 0, "R1 full b");

    // R5 reads while empty do nothing
    rd_want_a = 1; rd_want_b = 1; wcyc(4); rd_want_a = 0; rd_want_b = 0; wcyc(2);
    chk1(empty_a, 1, "R5 still empty");

    // R3 / R4 fill beyond capacity, keep writing while full
    wr_want_a = 1; wr_want_b = 1; wcyc(16); wr_want_a = 0; wr_want_b = 0; wcyc(8);
    chk(qa.size() == 9, "R3 capacity a", W'(qa.size()), W'(9));
    chk(qb.size() == 9, "R3 capacity b", W'(qb.size()), W'(9));
    chk_levels("filled");
    wr_want_a = 1; wr_want_b = 1; wcyc(3); wr_want_a = 0; wr_want_b = 0; wcyc(4);
    chk(qa.size() == 9, "R4 write while full", W'(qa.size()), W'(9));
    drain();
    chk_levels("drained");

    // R9 / R10 thresholds, one word at a time
    for (int n = 1; n <= 9; n++) begin
      put_one();
      wcyc(8);
      chk(qa.size() == n, "R9 count", W'(qa.size()), W'(n));
      chk_levels("step");
    end
    drain();

    // R2 concurrent random traffic on both clocks
    for (int i = 0; i < 3000; i++) begin
      @(posedge rclk); #1;
      wr_want_a = ($urandom % 3) != 0; wr_want_b = ($urandom % 2) != 0;
      rd_want_a = ($urandom % 4) != 0; rd_want_b = ($urandom % 3) != 0;
    end
    wr_want_a = 0; wr_want_b = 0;
    drain();
    chk(qa.size() == 0, "R2 all words delivered a", W'(qa.size()), '0);
    chk(qb.size() == 0, "R2 all words delivered b", W'(qb.size()), '0);
    chk_levels("after stream");

    // R12 reset in the middle of traffic
    repeat (4) put_one();
    wcyc(4);
    do_reset();
    chk_levels("R12 after reset");
    chk1(empty_a, 1, "R12 empty");
    repeat (3) put_one();
    wcyc(8);
    chk(qa.size() == 3, "R12 refill", W'(qa.size()), W'(3));
    drain();
    chk_levels("R12 end");
    finish_run();
  end
endmodule